// File: doc/BRIEF.md
# Power-up coefficient RAM loader

This block fills a 32-bit coefficient RAM from a 2048 x 16 nonvolatile source memory once reset is released. The source memory is split into eight pages of 256 words, selected by the top three address bits. Pages 0 and 1 hold the factory coefficient set for all four channels; pages 2 and 3 may hold a custom set. The loader first reads one marker word, the first word of page 2 at address 0x200. When that word is nonzero, the custom pages are copied. When it is zero, the factory pages are copied.

The copy covers 512 source words in ascending order. Each even/odd pair of source words becomes one 32-bit RAM word. The even word goes in the upper half and the odd word in the lower half. The RAM address is the word's offset within the selected two-page region, shifted right by one. Each channel therefore sits at 0x80 steps in the source and at 0x40 steps in the RAM.

The source memory read latency may be any number of cycles. The loader keeps one read outstanding and waits for the read-valid strobe before it moves on. Until the last coefficient is written, the loader owns the RAM write port and external writes are dropped. After that, external writes pass straight through.

Top module: `coef_boot_loader`

## Requirements
- R1: While reset is held, `load_done` is 0, `load_busy` is 1, `src_rd_req` is 0 and `ram_wr_en` is 0.
- R2: The first read after reset is to source address 0x200. `src_rd_req` is never high in a cycle where `src_busy` is high.
- R3: When source word 0x200 reads as zero, the RAM receives source words 0x000 to 0x1FF.
- R4: When source word 0x200 reads as nonzero, the RAM receives source words 0x200 to 0x3FF. Word 0x200 itself is the first one copied.
- R5: RAM word k = {src[base+2k] in bits 31:16, src[base+2k+1] in bits 15:0}, where base is 0x000 or 0x200. Hence RAM 0x40, 0x80 and 0xC0 start channels B, C and D, taken from base+0x80, base+0x100 and base+0x180.
- R6: Exactly 256 loader writes are made, to RAM addresses 0x00 through 0xFF, in ascending order.
- R7: At most one read is outstanding. A new request waits until `src_rd_valid` has returned the previous word, and any read latency gives the same RAM contents.
- R8: `load_done` rises only after the last loader write. After that it stays high until reset, and `load_busy` is always its inverse.
- R9: Before `load_done`, the `ext_wr_*` inputs have no effect on the RAM port. After it, they drive `ram_wr_en`, `ram_wr_addr` and `ram_wr_data` in the same cycle.
- R10: A reset during a load aborts it, and the next release runs a complete fresh load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_busy | input | 1 | Source memory cannot accept a read this cycle |
| src_rd_req | output | 1 | Read request, taken with `src_addr` at the clock edge |
| src_addr | output | 11 | Source word address |
| src_rd_valid | input | 1 | One-cycle strobe: `src_rd_data` holds the requested word |
| src_rd_data | input | 16 | Source read data |
| ext_wr_en | input | 1 | External RAM write enable (honoured after load) |
| ext_wr_addr | input | 8 | External RAM write address |
| ext_wr_data | input | 32 | External RAM write data |
| ram_wr_en | output | 1 | Coefficient RAM write enable |
| ram_wr_addr | output | 8 | Coefficient RAM write address |
| ram_wr_data | output | 32 | Coefficient RAM write data |
| load_done | output | 1 | Load complete, held until reset |
| load_busy | output | 1 | Load in progress (inverse of `load_done`) |

## Verification
The assertions assume the source memory answers each accepted request with exactly one `src_rd_valid` pulse. They also assume that no pulse arrives without a request and that the pulse never comes in the same cycle as the request. The bench memory model follows these rules for every latency it is given: it queues one address, counts its wait cycles and returns a single strobe. It also flags any request that arrives while a read is pending or while `src_busy` is high. The busy line toggles in a fixed pattern, so requests are stalled repeatedly throughout each load.

// File: rtl/coef_boot_pkg.sv
// Shared types for the power-up coefficient loader.
package coef_boot_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_SENT_REQ,
        S_SENT_WAIT,
        S_LOAD_REQ,
        S_LOAD_WAIT,
        S_FLUSH,
        S_DONE
    } boot_state_t;
endpackage

// File: rtl/cbl_sequencer.sv
// Read sequencer: fetches the marker word, picks the page base and then walks
// the two-page region one word at a time.
// Assumes: one src_rd_valid pulse per accepted request, never in the request cycle.
module cbl_sequencer
    import coef_boot_pkg::*;
#(
    parameter int SRC_AW    = 11,
    parameter int DATA_W    = 16,
    parameter int PAGE_AW   = 8,
    parameter int DEF_PAGE  = 0,
    parameter int CUS_PAGE  = 2,
    localparam int REGION_AW = PAGE_AW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 src_busy,
    input  logic                 src_rd_valid,
    input  logic [DATA_W-1:0]    src_rd_data,
    output logic                 src_rd_req,
    output logic [SRC_AW-1:0]    src_addr,
    output logic                 word_fire,
    output logic [REGION_AW-1:0] word_idx,
    output logic [DATA_W-1:0]    word_data,
    output logic                 load_done
);
    localparam logic [SRC_AW-1:0]    SENT_ADDR = SRC_AW'(CUS_PAGE * (2 ** PAGE_AW));
    localparam logic [SRC_AW-1:0]    DEF_BASE  = SRC_AW'(DEF_PAGE * (2 ** PAGE_AW));
    localparam logic [SRC_AW-1:0]    CUS_BASE  = SENT_ADDR;
    localparam logic [REGION_AW-1:0] LAST_IDX  = REGION_AW'((2 ** REGION_AW) - 1);

    boot_state_t          state;
    logic [REGION_AW-1:0] idx;
    logic                 use_custom;
    logic [SRC_AW-1:0]    base;

    // Address and request generation from the current state.
    always_comb begin
        base       = use_custom ? CUS_BASE : DEF_BASE;
        src_addr   = (state == S_SENT_REQ || state == S_SENT_WAIT)
                     ? SENT_ADDR : base + SRC_AW'(idx);
        src_rd_req = (state == S_SENT_REQ || state == S_LOAD_REQ) && !src_busy;
        word_fire  = (state == S_LOAD_WAIT) && src_rd_valid;
        word_idx   = idx;
        word_data  = src_rd_data;
        load_done  = (state == S_DONE);
    end

    // Load sequence state, word index and page choice.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            idx        <= '0;
            use_custom <= 1'b0;
        end else begin
            case (state)
                S_IDLE:      state <= S_SENT_REQ;
                S_SENT_REQ:  if (src_rd_req) state <= S_SENT_WAIT;
                S_SENT_WAIT: if (src_rd_valid) begin
                    use_custom <= (src_rd_data != '0);
                    state      <= S_LOAD_REQ;
                end
                S_LOAD_REQ:  if (src_rd_req) state <= S_LOAD_WAIT;
                S_LOAD_WAIT: if (src_rd_valid) begin
                    if (idx == LAST_IDX) begin
                        state <= S_FLUSH;
                    end else begin
                        idx   <= idx + 1'b1;
                        state <= S_LOAD_REQ;
                    end
                end
                S_FLUSH:     state <= S_DONE;
                default:     state <= S_DONE;
            endcase
        end
    end
endmodule

// File: rtl/cbl_pair_packer.sv
// Pair packer: keeps the even source word and, on the odd one, issues a
// registered 32-bit write at the pair's half-address.
// Assumes: words arrive in ascending index order starting at an even index.
module cbl_pair_packer #(
    parameter int DATA_W    = 16,
    parameter int REGION_AW = 9,
    localparam int DST_AW   = REGION_AW - 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 word_fire,
    input  logic [REGION_AW-1:0] word_idx,
    input  logic [DATA_W-1:0]    word_data,
    output logic                 wr_en,
    output logic [DST_AW-1:0]    wr_addr,
    output logic [2*DATA_W-1:0]  wr_data
);
    logic [DATA_W-1:0] hi_half;

    // Capture the upper half and emit the joined word one cycle after the odd word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_half <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (word_fire) begin
                if (!word_idx[0]) begin
                    hi_half <= word_data;
                end else begin
                    wr_en   <= 1'b1;
                    wr_addr <= word_idx[REGION_AW-1:1];
                    wr_data <= {hi_half, word_data};
                end
            end
        end
    end
endmodule

// File: rtl/cbl_write_mux.sv
// RAM port owner: the loader while loading, the external port afterwards.
// Assumes: load_done never falls except through reset.
module cbl_write_mux #(
    parameter int DST_AW = 8,
    parameter int WORD_W = 32
) (
    input  logic              load_done,
    input  logic              ld_wr_en,
    input  logic [DST_AW-1:0] ld_wr_addr,
    input  logic [WORD_W-1:0] ld_wr_data,
    input  logic              ext_wr_en,
    input  logic [DST_AW-1:0] ext_wr_addr,
    input  logic [WORD_W-1:0] ext_wr_data,
    output logic              ram_wr_en,
    output logic [DST_AW-1:0] ram_wr_addr,
    output logic [WORD_W-1:0] ram_wr_data
);
    // Select the write source by load phase.
    always_comb begin
        if (load_done) begin
            ram_wr_en   = ext_wr_en;
            ram_wr_addr = ext_wr_addr;
            ram_wr_data = ext_wr_data;
        end else begin
            ram_wr_en   = ld_wr_en;
            ram_wr_addr = ld_wr_addr;
            ram_wr_data = ld_wr_data;
        end
    end
endmodule

// File: rtl/coef_boot_loader.sv
// Top: power-up coefficient loader. Chooses the factory or the custom page pair
// from a marker word and copies it as packed 32-bit words into the coefficient RAM.
// Assumes: source memory with busy/valid handshake and arbitrary read latency.
module coef_boot_loader #(
    parameter int SRC_AW   = 11,
    parameter int DATA_W   = 16,
    parameter int PAGE_AW  = 8,
    parameter int DEF_PAGE = 0,
    parameter int CUS_PAGE = 2,
    localparam int REGION_AW = PAGE_AW + 1,
    localparam int DST_AW    = REGION_AW - 1,
    localparam int WORD_W    = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_busy,
    output logic              src_rd_req,
    output logic [SRC_AW-1:0] src_addr,
    input  logic              src_rd_valid,
    input  logic [DATA_W-1:0] src_rd_data,
    input  logic              ext_wr_en,
    input  logic [DST_AW-1:0] ext_wr_addr,
    input  logic [WORD_W-1:0] ext_wr_data,
    output logic              ram_wr_en,
    output logic [DST_AW-1:0] ram_wr_addr,
    output logic [WORD_W-1:0] ram_wr_data,
    output logic              load_done,
    output logic              load_busy
);
    logic                 word_fire;
    logic [REGION_AW-1:0] word_idx;
    logic [DATA_W-1:0]    word_data;
    logic                 ld_wr_en;
    logic [DST_AW-1:0]    ld_wr_addr;
    logic [WORD_W-1:0]    ld_wr_data;

    cbl_sequencer #(
        .SRC_AW(SRC_AW), .DATA_W(DATA_W), .PAGE_AW(PAGE_AW),
        .DEF_PAGE(DEF_PAGE), .CUS_PAGE(CUS_PAGE)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .src_busy(src_busy),
        .src_rd_valid(src_rd_valid), .src_rd_data(src_rd_data),
        .src_rd_req(src_rd_req), .src_addr(src_addr),
        .word_fire(word_fire), .word_idx(word_idx), .word_data(word_data),
        .load_done(load_done)
    );

    cbl_pair_packer #(.DATA_W(DATA_W), .REGION_AW(REGION_AW)) u_pack (
        .clk(clk), .rst_n(rst_n), .word_fire(word_fire),
        .word_idx(word_idx), .word_data(word_data),
        .wr_en(ld_wr_en), .wr_addr(ld_wr_addr), .wr_data(ld_wr_data)
    );

    cbl_write_mux #(.DST_AW(DST_AW), .WORD_W(WORD_W)) u_mux (
        .load_done(load_done),
        .ld_wr_en(ld_wr_en), .ld_wr_addr(ld_wr_addr), .ld_wr_data(ld_wr_data),
        .ext_wr_en(ext_wr_en), .ext_wr_addr(ext_wr_addr), .ext_wr_data(ext_wr_data),
        .ram_wr_en(ram_wr_en), .ram_wr_addr(ram_wr_addr), .ram_wr_data(ram_wr_data)
    );

    // Busy status is the complement of completion.
    assign load_busy = !load_done;
endmodule

// File: rtl/coef_boot_loader_chk.sv
// Protocol and ordering checker for coef_boot_loader, attached by bind.
module coef_boot_loader_chk #(
    parameter int DST_AW = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              src_busy,
    input logic              src_rd_req,
    input logic              src_rd_valid,
    input logic              ram_wr_en,
    input logic [DST_AW-1:0] ram_wr_addr,
    input logic              load_done,
    input logic              load_busy
);
    logic            pending;
    logic [DST_AW:0] wr_count;

    // Track the outstanding read and the number of loader writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending  <= 1'b0;
            wr_count <= '0;
        end else begin
            if (src_rd_req)        pending <= 1'b1;
            else if (src_rd_valid) pending <= 1'b0;
            if (ram_wr_en && !load_done) wr_count <= wr_count + 1'b1;
        end
    end

    a_r2_req_only_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        src_rd_req |-> !src_busy);
    a_r7_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        src_rd_req |-> !pending);
    a_r6_ascending_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_wr_en && !load_done) |-> (ram_wr_addr == wr_count[DST_AW-1:0]));
    a_r8_all_written: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_done) |-> (wr_count == (DST_AW+1)'(2 ** DST_AW)));
    a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> load_done);
    a_r8_busy_inverse: assert property (@(posedge clk) disable iff (!rst_n)
        load_busy == !load_done);
endmodule

bind coef_boot_loader coef_boot_loader_chk #(.DST_AW(DST_AW)) i_chk (
    .clk(clk), .rst_n(rst_n), .src_busy(src_busy), .src_rd_req(src_rd_req),
    .src_rd_valid(src_rd_valid), .ram_wr_en(ram_wr_en), .ram_wr_addr(ram_wr_addr),
    .load_done(load_done), .load_busy(load_busy)
);

// File: tb/test_coef_boot_loader.sv
// Directed bench: source memory model with variable latency and busy stalls.
module test_coef_boot_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        src_busy = 1'b0;
    logic        src_rd_req;
    logic [10:0] src_addr;
    logic        src_rd_valid = 1'b0;
    logic [15:0] src_rd_data = '0;
    logic        ext_wr_en = 1'b0;
    logic [7:0]  ext_wr_addr = '0;
    logic [31:0] ext_wr_data = '0;
    logic        ram_wr_en;
    logic [7:0]  ram_wr_addr;
    logic [31:0] ram_wr_data;
    logic        load_done;
    logic        load_busy;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int lat = 2;

    logic [15:0] mem [2048];
    logic [31:0] dst [256];
    int wr_cnt, order_viol, busy_viol, pend_viol, last_wr_cyc, done_cyc;
    logic [10:0] first_addr;
    logic first_seen, done_seen, pend;
    int cnt;
    logic [10:0] aq;

    always #4 clk = ~clk;

    coef_boot_loader i_coef_boot_loader (
        .clk(clk), .rst_n(rst_n), .src_busy(src_busy), .src_rd_req(src_rd_req),
        .src_addr(src_addr), .src_rd_valid(src_rd_valid), .src_rd_data(src_rd_data),
        .ext_wr_en(ext_wr_en), .ext_wr_addr(ext_wr_addr), .ext_wr_data(ext_wr_data),
        .ram_wr_en(ram_wr_en), .ram_wr_addr(ram_wr_addr), .ram_wr_data(ram_wr_data),
        .load_done(load_done), .load_busy(load_busy)
    );

    // Cycle counter, busy pattern and watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        src_busy <= ((cyc % 7) < 3);
        if (cyc > 190000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<190000", cyc);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Source memory model: one outstanding read, lat extra wait cycles.
    always @(posedge clk) begin
        src_rd_valid <= 1'b0;
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (src_rd_req) begin
            pend <= 1'b1; cnt <= lat; aq <= src_addr;
        end else if (pend) begin
            if (cnt == 0) begin
                src_rd_valid <= 1'b1; src_rd_data <= mem[aq]; pend <= 1'b0;
            end else cnt <= cnt - 1;
        end
    end

    // Observation of requests and loader writes away from the clock edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            wr_cnt = 0; order_viol = 0; busy_viol = 0; pend_viol = 0;
            last_wr_cyc = 0; done_cyc = 0; first_seen = 0; done_seen = 0;
        end else begin
            if (src_rd_req && src_busy) busy_viol = busy_viol + 1;
            if (src_rd_req && pend) pend_viol = pend_viol + 1;
            if (src_rd_req && !first_seen) begin first_addr = src_addr; first_seen = 1; end
            if (ram_wr_en && !load_done) begin
                if (ram_wr_addr != 8'(wr_cnt)) order_viol = order_viol + 1;
                dst[ram_wr_addr] = ram_wr_data;
                wr_cnt = wr_cnt + 1;
                last_wr_cyc = cyc;
            end
            if (load_done && !done_seen) begin done_seen = 1; done_cyc = cyc; end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic fill_mem(input logic [15:0] marker);
        for (int a = 0; a < 2048; a++) mem[a] = 16'((a * 40503) ^ 16'h3C5A);
        mem[11'h200] = marker;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 30000 && !load_done; i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_load(input int base, input string rq);
        int bad = 0;
        for (int k = 0; k < 256; k++)
            if (dst[k] !== {mem[base + 2*k], mem[base + 2*k + 1]}) bad++;
        chk(load_done == 1'b1, "R8 done", load_done, 1);
        chk(wr_cnt == 256, "R6 count", wr_cnt, 256);
        chk(order_viol == 0, "R6 order", order_viol, 0);
        chk(bad == 0, rq, bad, 0);
        chk(dst[8'h40] === {mem[base+'h80], mem[base+'h81]}, "R5 chB", dst[8'h40], {mem[base+'h80], mem[base+'h81]});
        chk(dst[8'hC0] === {mem[base+'h180], mem[base+'h181]}, "R5 chD", dst[8'hC0], {mem[base+'h180], mem[base+'h181]});
        chk(first_addr == 11'h200, "R2 first addr", first_addr, 11'h200);
        chk(busy_viol == 0, "R2 busy", busy_viol, 0);
        chk(pend_viol == 0, "R7 outstanding", pend_viol, 0);
        chk(done_cyc > last_wr_cyc, "R8 after last write", done_cyc, last_wr_cyc + 1);
        chk(load_busy == !load_done, "R8 busy inverse", load_busy, !load_done);
    endtask

    task automatic test_reset_state();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(load_done == 0 && load_busy == 1, "R1 status", {load_done, load_busy}, 2'b01);
        chk(src_rd_req == 0 && ram_wr_en == 0, "R1 ports", {src_rd_req, ram_wr_en}, 0);
    endtask

    task automatic test_default(input int l);
        lat = l; fill_mem(16'h0000); do_reset(); wait_done();
        check_load(0, "R3 factory pages");
        repeat (20) @(negedge clk);
        chk(load_done == 1, "R8 sticky", load_done, 1);
    endtask

    task automatic test_custom(input int l);
        lat = l; fill_mem(16'h0001); do_reset(); wait_done();
        check_load('h200, "R4 custom pages");
        chk(dst[0][31:16] == 16'h0001, "R4 marker copied", dst[0][31:16], 1);
    endtask

    task automatic test_ext_port();
        lat = 1; fill_mem(16'h0000);
        ext_wr_en = 1'b1; ext_wr_addr = 8'h5A; ext_wr_data = 32'hDEADBEEF;
        do_reset(); wait_done();
        ext_wr_en = 1'b0;
        check_load(0, "R9 ext ignored during load");
        @(negedge clk);
        ext_wr_en = 1'b1; ext_wr_addr = 8'hA7; ext_wr_data = 32'h12345678;
        #1;
        chk(ram_wr_en && ram_wr_addr == 8'hA7 && ram_wr_data == 32'h12345678,
            "R9 ext passes", {ram_wr_en, ram_wr_addr, ram_wr_data}, {1'b1, 8'hA7, 32'h12345678});
        @(negedge clk); ext_wr_en = 1'b0; #1;
        chk(ram_wr_en == 0, "R9 ext released", ram_wr_en, 0);
    endtask

    task automatic test_midload_reset();
        lat = 2; fill_mem(16'h0007); do_reset();
        for (int i = 0; i < 30000 && wr_cnt < 100; i++) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        chk(load_done == 0 && ram_wr_en == 0, "R10 abort", {load_done, ram_wr_en}, 0);
        rst_n = 1'b1;
        wait_done();
        check_load('h200, "R10 full reload");
    endtask

    initial begin
        test_reset_state();
        test_default(0);
        test_default(5);
        test_custom(3);
        test_ext_port();
        test_midload_reset();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule